// File: doc/BRIEF.md
# Audio Control Register Target (Two-Wire, Write-Only)

This block is a write-only target on a two-wire serial control bus, the I2C bus, and holds the eight control registers of a stereo audio control chip. It oversamples the serial clock and data lines on a fast system clock. It detects START and STOP conditions, recognises a fixed device address and pulls the data line low to acknowledge. It then steers every following data byte into the register array.

The first byte after the address is a subaddress. Its low nibble is a 4-bit register index and bit 4 selects auto-increment. Indices 0 to 7 map to the registers; indices 8 to 15 are legal positions, but bytes aimed there are thrown away. All eight registers are visible in parallel and come out of reset with fixed, mostly non-zero settings. A one-cycle strobe with the register index marks every stored byte.

Top module: `audio_ctl_i2c_regs`

## Requirements
- R1: After reset the registers hold, by index: 0 = 0x02, 1 = 0x0E, 2 = 0x70, 3 = 0x07, 4 = 0x0E, 5 = 0x0E, 6 = 0xF8, 7 = 0xF8. The illegal-select flag is 0 and the data line is released.
- R2: A START is the data line falling while the clock is high, and a STOP is the data line rising while the clock is high. Data bits are taken MSB first on rising clock edges. After the address byte 0x88 (address 7'h44, write bit 0), the target drives the data line low for the whole high phase of the ninth clock.
- R3: Any other address byte, including the read form 0x89, gets no acknowledge. Every byte up to the next START or STOP is then left unacknowledged and writes nothing.
- R4: With subaddress bit 4 clear, each data byte up to STOP is written to the one register selected by subaddress bits [3:0]. The last byte remains.
- R5: With subaddress bit 4 set, the first data byte goes to the selected index and each later byte goes to the previous index plus one.
- R6: Bytes aimed at indices 8 to 15 change no register, yet are acknowledged. Under auto-increment the index wraps from 15 to 0 and writes resume there.
- R7: A data byte stored at index 0 with bits [1:0] = 2'b01 is written as sent, and it also sets a flag that stays set until reset.
- R8: A repeated START, with no STOP before it, restarts address decoding, including after a rejected address.
- R9: Every stored byte raises the write strobe for exactly one system clock, with the register index beside it. No register changes without the strobe.
- R10: Subaddress bits [7:5] have no effect on index or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| regs_o | output | 64 | All eight registers, index i at bits [8i+7:8i] |
| wr_stb_o | output | 1 | One-cycle pulse per stored byte |
| wr_idx_o | output | 3 | Register index of the stored byte |
| illegal_sel_o | output | 1 | Sticky flag for a forbidden input-select code |

## Verification
Directed frames check single-register overwrite, an auto-increment run that crosses into the dropped indices, and a run that wraps from 15 back to 0. Each of these gives a different register image and strobe count if the index logic is wrong. Rejected addresses, the read form and a repeated START after a rejected address tell apart a decoder that re-arms only on START or STOP from one that leaks writes. Random frames with random subaddresses, flags, lengths and data, mixed with a few foreign addresses, are compared byte by byte against a bench model of the register array.

// File: rtl/ac_i2c_pkg.sv
package ac_i2c_pkg;
  localparam int NREG  = 8;
  localparam int DW    = 8;
  localparam int IDXW  = 4;
  localparam int RW    = $clog2(NREG);
  localparam int SEL_IDX = 0;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_SUB, PH_DATA, PH_SKIP
  } phase_e;

  function automatic logic [DW-1:0] reg_default(input int i);
    case (i)
      0:       return 8'h02;
      1:       return 8'h0E;
      2:       return 8'h70;
      3:       return 8'h07;
      4:       return 8'h0E;
      5:       return 8'h0E;
      default: return 8'hF8;
    endcase
  endfunction
endpackage

// File: rtl/ac_line_sync.sv
module ac_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_n;

  always_comb sh_n = {sh_q[STAGES-1:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_n;
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/ac_byte_rx.sv
module ac_byte_rx
  import ac_i2c_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h44
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          sda_rise,
  input  logic          sda_fall,
  output logic          byte_vld_o,
  output logic [DW-1:0] byte_o,
  output phase_e        kind_o,
  output logic          sda_oe_o
);
  localparam logic [DW-1:0] ADDR_BYTE = {ADDR7, 1'b0};

  phase_e        phase_q, phase_n, kind_q, kind_n;
  logic [3:0]    cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n, nxt_byte;
  logic          oe_q, oe_n, ackp_q, ackp_n, vld_q, vld_n;
  logic          start_c, stop_c;

  assign start_c  = scl_lvl & sda_fall;
  assign stop_c   = scl_lvl & sda_rise;
  assign nxt_byte = {sh_q[DW-2:0], sda_lvl};

  always_comb begin
    phase_n = phase_q;
    kind_n  = kind_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    oe_n    = oe_q;
    ackp_n  = ackp_q;
    vld_n   = 1'b0;
    if (stop_c) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else if (start_c) begin
      phase_n = PH_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise && cnt_q < 4'd8) begin
        sh_n  = nxt_byte;
        cnt_n = cnt_q + 4'd1;
        if (cnt_q == 4'd7) begin
          vld_n  = 1'b1;
          kind_n = phase_q;
          ackp_n = 1'b0;
          case (phase_q)
            PH_ADDR: begin
              if (nxt_byte == ADDR_BYTE) begin
                phase_n = PH_SUB;
                ackp_n  = 1'b1;
              end else begin
                phase_n = PH_SKIP;
              end
            end
            PH_SUB:  begin phase_n = PH_DATA; ackp_n = 1'b1; end
            PH_DATA: ackp_n = 1'b1;
            default: ackp_n = 1'b0;
          endcase
        end
      end else if (scl_fall && cnt_q == 4'd8) begin
        cnt_n = 4'd9;
        oe_n  = ackp_q;
      end else if (scl_fall && cnt_q == 4'd9) begin
        cnt_n = '0;
        oe_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      ackp_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      kind_q  <= kind_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      oe_q    <= oe_n;
      ackp_q  <= ackp_n;
      vld_q   <= vld_n;
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = sh_q;
  assign kind_o     = kind_q;
  assign sda_oe_o   = oe_q;

  // R2: the pull-down starts only while the serial clock is low
  p_ack_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_lvl);
  // R2: the pull-down is confined to the acknowledge slot
  p_ack_in_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (cnt_q == 4'd9));
  // R3: a rejected frame never drives the line
  p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP) |-> !oe_q);
  // R8: a START always rearms address decoding
  p_start_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && !stop_c) |=> (phase_q == PH_ADDR && cnt_q == 4'd0));
endmodule

// File: rtl/ac_reg_bank.sv
module ac_reg_bank
  import ac_i2c_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byte_vld,
  input  logic [DW-1:0]          byte_i,
  input  phase_e                 kind_i,
  output logic [NREG-1:0][DW-1:0] regs_o,
  output logic                   wr_stb_o,
  output logic [RW-1:0]          wr_idx_o,
  output logic                   illegal_o
);
  logic [NREG-1:0][DW-1:0] regs_q, regs_n;
  logic [IDXW-1:0]         idx_q, idx_n;
  logic                    inc_q, inc_n, stb_q, stb_n, ill_q, ill_n;
  logic [RW-1:0]           widx_q, widx_n;
  logic                    in_range;

  assign in_range = (idx_q[IDXW-1:RW] == '0);

  always_comb begin
    regs_n = regs_q;
    idx_n  = idx_q;
    inc_n  = inc_q;
    ill_n  = ill_q;
    widx_n = widx_q;
    stb_n  = 1'b0;
    if (byte_vld && kind_i == PH_SUB) begin
      idx_n = byte_i[IDXW-1:0];
      inc_n = byte_i[IDXW];
    end else if (byte_vld && kind_i == PH_DATA) begin
      if (in_range) begin
        regs_n[idx_q[RW-1:0]] = byte_i;
        stb_n  = 1'b1;
        widx_n = idx_q[RW-1:0];
        if (idx_q == IDXW'(SEL_IDX) && byte_i[1:0] == 2'b01) ill_n = 1'b1;
      end
      if (inc_q) idx_n = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= reg_default(i);
      idx_q  <= '0;
      inc_q  <= 1'b0;
      ill_q  <= 1'b0;
      widx_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      regs_q <= regs_n;
      idx_q  <= idx_n;
      inc_q  <= inc_n;
      ill_q  <= ill_n;
      widx_q <= widx_n;
      stb_q  <= stb_n;
    end
  end

  assign regs_o    = regs_q;
  assign wr_stb_o  = stb_q;
  assign wr_idx_o  = widx_q;
  assign illegal_o = ill_q;

  // R9: register contents move only together with the strobe
  p_quiet_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> $stable(regs_q));
  // R9: a strobe lasts one cycle, bytes arrive far apart
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  // R7: the illegal-select flag never clears
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |=> ill_q);
endmodule

// File: rtl/audio_ctl_i2c_regs.sv
module audio_ctl_i2c_regs
  import ac_i2c_pkg::*;
#(
  parameter logic [6:0] ADDR7       = 7'h44,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe_o,
  output logic [NREG*DW-1:0]       regs_o,
  output logic                     wr_stb_o,
  output logic [RW-1:0]            wr_idx_o,
  output logic                     illegal_sel_o
);
  logic [1:0] rst_sh_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_s_n = rst_sh_q[1];

  logic [1:0] pin_in, lvl, rise, fall;
  assign pin_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    ac_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .d_i    (pin_in[g]),
      .lvl_o  (lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  logic                    bvld;
  logic [DW-1:0]           bdat;
  phase_e                  bkind;
  logic [NREG-1:0][DW-1:0] regs_w;

  ac_byte_rx #(.ADDR7(ADDR7)) u_rx (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .scl_lvl    (lvl[0]),
    .scl_rise   (rise[0]),
    .scl_fall   (fall[0]),
    .sda_lvl    (lvl[1]),
    .sda_rise   (rise[1]),
    .sda_fall   (fall[1]),
    .byte_vld_o (bvld),
    .byte_o     (bdat),
    .kind_o     (bkind),
    .sda_oe_o   (sda_oe_o)
  );

  ac_reg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .byte_vld  (bvld),
    .byte_i    (bdat),
    .kind_i    (bkind),
    .regs_o    (regs_w),
    .wr_stb_o  (wr_stb_o),
    .wr_idx_o  (wr_idx_o),
    .illegal_o (illegal_sel_o)
  );

  assign regs_o = regs_w;

  // R3: only acknowledged frames store bytes, so a strobe never coincides with a drive of the line
  p_no_strobe_during_ack_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_stb_o |-> !sda_oe_o);
endmodule

// File: tb/audio_ctl_i2c_regs_tb.sv
module audio_ctl_i2c_regs_tb;
  localparam int HALF = 8;
  localparam int QTR  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_m, sda_m;
  logic        sda_oe;
  logic [63:0] regs;
  logic        wr_stb;
  logic [2:0]  wr_idx;
  logic        ill;
  logic        sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  audio_ctl_i2c_regs u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_m),
    .sda_i         (sda_line),
    .sda_oe_o      (sda_oe),
    .regs_o        (regs),
    .wr_stb_o      (wr_stb),
    .wr_idx_o      (wr_idx),
    .illegal_sel_o (ill)
  );

  int nchk = 0;
  int nerr = 0;
  int stb_cnt = 0;
  int idx_bad = 0;
  logic [7:0] exp_r [8];
  logic       exp_ill;
  logic [7:0] tx_d [8];
  int         exp_idx_q [$];

  always @(posedge clk) begin
    if (wr_stb) begin
      stb_cnt <= stb_cnt + 1;
      if (exp_idx_q.size() == 0 || int'(wr_idx) != exp_idx_q[0]) idx_bad <= idx_bad + 1;
      if (exp_idx_q.size() != 0) void'(exp_idx_q.pop_front());
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(HALF);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b0; wt(HALF);
    scl_m = 1'b0; wt(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HALF);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b1; wt(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(HALF);
      scl_m = 1'b1; wt(HALF);
      scl_m = 1'b0; wt(QTR);
    end
    sda_m = 1'b1; wt(HALF);
    scl_m = 1'b1; wt(QTR);
    ack = !sda_line;
    wt(HALF - QTR);
    scl_m = 1'b0; wt(QTR);
  endtask

  task automatic cmp_regs(input string req);
    for (int i = 0; i < 8; i++)
      chk(regs[i*8 +: 8] == exp_r[i], req, 64'(regs[i*8 +: 8]), 64'(exp_r[i]));
  endtask

  // One whole frame with the expected image computed from the requirements
  task automatic xfer(input logic [7:0] ab, input logic [7:0] sb, input int n, input string req);
    bit ack;
    bit hit;
    int base;
    int idx;
    base = stb_cnt;
    idx_bad = 0;
    hit = (ab == 8'h88);
    idx = int'(sb[3:0]);
    bus_start();
    send_byte(ab, ack);
    chk(ack == hit, {req, " R2/R3 address ack"}, 64'(ack), 64'(hit));
    send_byte(sb, ack);
    chk(ack == hit, {req, " R3 subaddress ack"}, 64'(ack), 64'(hit));
    for (int k = 0; k < n; k++) begin
      if (hit && idx < 8) begin
        exp_idx_q.push_back(idx);
        exp_r[idx] = tx_d[k];
        if (idx == 0 && tx_d[k][1:0] == 2'b01) exp_ill = 1'b1;
      end
      send_byte(tx_d[k], ack);
      chk(ack == hit, {req, " R6 data ack"}, 64'(ack), 64'(hit));
      if (hit && sb[4]) idx = (idx + 1) % 16;
    end
    bus_stop();
    wt(8);
    begin
      int exp_n;
      exp_n = 0;
      idx = int'(sb[3:0]);
      for (int k = 0; k < n; k++) begin
        if (hit && idx < 8) exp_n++;
        if (sb[4]) idx = (idx + 1) % 16;
      end
      chk(stb_cnt - base == exp_n, {req, " R9 strobe count"}, 64'(stb_cnt - base), 64'(exp_n));
    end
    chk(idx_bad == 0, {req, " R9 strobe index"}, 64'(idx_bad), 64'(0));
    cmp_regs(req);
    chk(ill == exp_ill, {req, " R7 flag"}, 64'(ill), 64'(exp_ill));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    bit ack;
    void'($urandom(32'h1A7E));
    scl_m = 1'b1;
    sda_m = 1'b1;
    rst_n = 1'b0;
    wt(5);
    rst_n = 1'b1;
    wt(5);

    // R1 reset image
    exp_r[0] = 8'h02; exp_r[1] = 8'h0E; exp_r[2] = 8'h70; exp_r[3] = 8'h07;
    exp_r[4] = 8'h0E; exp_r[5] = 8'h0E; exp_r[6] = 8'hF8; exp_r[7] = 8'hF8;
    exp_ill = 1'b0;
    cmp_regs("R1 reset");
    chk(ill == 1'b0, "R1 flag", 64'(ill), 64'(0));
    chk(sda_oe == 1'b0, "R1 line released", 64'(sda_oe), 64'(0));

    // R4 single register overwrite
    tx_d[0] = 8'h55; tx_d[1] = 8'h66; tx_d[2] = 8'h77;
    xfer(8'h88, 8'h03, 3, "R4 fixed index");

    // R5 + R6 increment runs into dropped indices
    tx_d[0] = 8'h11; tx_d[1] = 8'h22; tx_d[2] = 8'h33; tx_d[3] = 8'h44; tx_d[4] = 8'h55;
    xfer(8'h88, 8'h15, 5, "R5 increment");

    // R6 wrap from 15 to 0
    tx_d[0] = 8'hA1; tx_d[1] = 8'hB2; tx_d[2] = 8'h03; tx_d[3] = 8'h3C;
    xfer(8'h88, 8'h1E, 4, "R6 wrap");

    // R10 upper subaddress bits
    tx_d[0] = 8'h05; tx_d[1] = 8'h09;
    xfer(8'h88, 8'hE1, 2, "R10 dont-care bits");

    // R3 foreign address and read form
    tx_d[0] = 8'h00; tx_d[1] = 8'h00;
    xfer(8'h8A, 8'h13, 2, "R3 wrong address");
    xfer(8'h89, 8'h02, 2, "R3 read bit");

    // R8 repeated START after a rejected address
    bus_start();
    send_byte(8'h10, ack);
    chk(!ack, "R8 rejected before restart", 64'(ack), 64'(0));
    bus_start();
    send_byte(8'h88, ack);
    chk(ack, "R8 address after restart", 64'(ack), 64'(1));
    send_byte(8'h02, ack);
    exp_idx_q.push_back(2);
    send_byte(8'h2A, ack);
    chk(ack, "R8 data ack", 64'(ack), 64'(1));
    bus_stop();
    wt(8);
    exp_r[2] = 8'h2A;
    cmp_regs("R8 restart write");

    // R7 forbidden select code, then a legal one
    tx_d[0] = 8'h01;
    xfer(8'h88, 8'h00, 1, "R7 forbidden code");
    tx_d[0] = 8'h03;
    xfer(8'h88, 8'h00, 1, "R7 flag holds");

    // Random frames
    for (int t = 0; t < 40; t++) begin
      logic [7:0] ab, sb;
      int n;
      ab = ($urandom % 6 == 0) ? 8'($urandom) : 8'h88;
      sb = 8'($urandom);
      n  = 1 + int'($urandom % 6);
      for (int k = 0; k < 8; k++) tx_d[k] = 8'($urandom);
      xfer(ab, sb, n, "R5/R4 random");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule